// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog timer driven by software through a small register set behind a plain read/write strobe port. The system clock goes through two stages before it reaches the counter. The first stage is an 8-bit linear prescaler that divides by P+1. The second stage is a post-divider that divides by a selectable power of two from 16 to 128. Each tick from the second stage moves a 16-bit down counter one step.

When a tick finds the counter at zero, the counter expires and reloads from the reload register. Depending on the control bits, expiry latches an interrupt, issues a one-cycle reset request, or does both. Software keeps the system alive by writing a fresh value into the count register before the counter expires. A pending interrupt is dropped by writing any value to the clear offset.

Top module: `prescaled_wdt`

## Requirements
- R1: After reset, the control register reads 0x0000, the reload and count registers read 0xFFFF, and irqOut and rstReq are low.
- R2: The control register sits at offset 0x0, the reload register at 0x4 and the count register at 0x8. Each reads back what was last written to it. Control keeps only bit 0 (reset enable), bit 2 (interrupt enable), bits [4:3] (divider select), bit 5 (run) and bits [15:8] (prescale P); every other control bit reads 0.
- R3: While run is set, the counter steps down by one every (P+1)·2^(4+sel) clock cycles, which is 16, 32, 64 or 128 for sel = 0 to 3. The first step after run is set comes a full period after the control write.
- R4: A tick that finds the counter at zero is an expiry, and the counter reloads from the reload register on that tick.
- R5: An expiry with interrupt enable set raises irqOut. irqOut stays high until any value is written to offset 0xC.
- R6: An expiry with reset enable set drives rstReq high for exactly one cycle, in the cycle after the expiry tick.
- R7: While run is clear, the counter holds and rstReq stays low. Clearing run also zeroes both divider stages, so turning run back on restarts a full period.
- R8: A write to the count register loads the written value at once and takes priority over a tick on the same edge.
- R9: A read of offset 0xC returns 0 and leaves a pending interrupt in place.
- R10: An expiry with interrupt enable and reset enable both clear still reloads the counter, but raises neither irqOut nor rstReq.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe, taken on the rising clock edge |
| rdEn | input | 1 | Read strobe; rdData is combinational while it is high |
| addr | input | 4 | Register byte offset |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data; 0 when rdEn is low or the offset is not mapped |
| irqOut | output | 1 | Pending expiry interrupt, level |
| rstReq | output | 1 | Reset request, one-cycle pulse |

## Verification
The assertions check the following on every cycle:
- the counter holds while it is stopped;
- a stopped or reset-disabled timer never requests a reset;
- a reset request lasts one cycle;
- refresh loads are exact;
- single-step decrements and reloads on expiry behave as specified;
- an interrupt clear takes effect;
- the control register changes only when it is written.

The absolute tick period for a given prescale and divider setting, and the full-period restart after run toggles, can only be shown by the bench's timed scenarios. The same holds for the exact cycle in which expiry and the reset pulse appear, and for the refresh-versus-tick race on one edge.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int CNT_W    = 16;
  localparam int PRE_W    = 8;
  localparam int SEL_W    = 2;
  localparam int DIV_LOG0 = 4;
  localparam int DV_W     = DIV_LOG0 + (1 << SEL_W) - 1;
  localparam int ADDR_W   = 4;

  // control field positions
  localparam int B_RSTEN  = 0;
  localparam int B_IRQEN  = 2;
  localparam int B_SEL    = 3;
  localparam int B_RUN    = 5;
  localparam int B_PRE    = 8;
  localparam int CTRL_W   = B_PRE + PRE_W;
  localparam int DATA_W   = (CTRL_W > CNT_W) ? CTRL_W : CNT_W;

  localparam logic [ADDR_W-1:0] OFF_CTRL = 4'h0;
  localparam logic [ADDR_W-1:0] OFF_RELD = 4'h4;
  localparam logic [ADDR_W-1:0] OFF_CNT  = 4'h8;
  localparam logic [ADDR_W-1:0] OFF_CLR  = 4'hC;

  function automatic logic [CTRL_W-1:0] ctrlMask();
    logic [CTRL_W-1:0] m;
    m = '0;
    m[B_RSTEN] = 1'b1;
    m[B_IRQEN] = 1'b1;
    m[B_RUN]   = 1'b1;
    for (int i = 0; i < SEL_W; i++) m[B_SEL+i] = 1'b1;
    for (int i = 0; i < PRE_W; i++) m[B_PRE+i] = 1'b1;
    return m;
  endfunction

  typedef struct packed {
    logic             run;
    logic             irqEn;
    logic             rstEn;
    logic [SEL_W-1:0] divSel;
    logic [PRE_W-1:0] presc;
    logic [CNT_W-1:0] reload;
    logic             loadCnt;
    logic [CNT_W-1:0] loadVal;
    logic             clrIrq;
  } wdt_ctl_t;
endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [CNT_W-1:0]  cntVal,
  output wdt_ctl_t          ctl
);
  localparam logic [CTRL_W-1:0] CTRL_MASK = ctrlMask();

  logic [CTRL_W-1:0] ctrlQ;
  logic [CNT_W-1:0]  reloadQ;

  wire wrCtrl = wrEn && (addr == OFF_CTRL);
  wire wrReld = wrEn && (addr == OFF_RELD);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ   <= '0;
      reloadQ <= '1;
    end else begin
      if (wrCtrl) ctrlQ   <= wrData[CTRL_W-1:0] & CTRL_MASK;
      if (wrReld) reloadQ <= wrData[CNT_W-1:0];
    end
  end

  always_comb begin
    ctl.run     = ctrlQ[B_RUN];
    ctl.irqEn   = ctrlQ[B_IRQEN];
    ctl.rstEn   = ctrlQ[B_RSTEN];
    ctl.divSel  = ctrlQ[B_SEL +: SEL_W];
    ctl.presc   = ctrlQ[B_PRE +: PRE_W];
    ctl.reload  = reloadQ;
    ctl.loadCnt = wrEn && (addr == OFF_CNT);
    ctl.loadVal = wrData[CNT_W-1:0];
    ctl.clrIrq  = wrEn && (addr == OFF_CLR);
  end

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      unique case (addr)
        OFF_CTRL: rdData = DATA_W'(ctrlQ);
        OFF_RELD: rdData = DATA_W'(reloadQ);
        OFF_CNT:  rdData = DATA_W'(cntVal);
        default:  rdData = '0;
      endcase
    end
  end

  // control changes only through a write to its own offset
  p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !wrCtrl |=> $stable(ctrlQ));
endmodule

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  wdt_ctl_t         ctl,
  output logic [CNT_W-1:0] count,
  output logic             irqPend,
  output logic             rstReq
);
  logic [PRE_W-1:0] psCnt;
  logic [DV_W-1:0]  dvCnt;
  logic [DV_W-1:0]  dvLimit;
  logic             preTick, tick, expire;

  always_comb begin
    dvLimit = '0;
    for (int i = 0; i < DV_W; i++)
      if (i < DIV_LOG0 + int'(ctl.divSel)) dvLimit[i] = 1'b1;
  end

  assign preTick = ctl.run && (psCnt >= ctl.presc);
  assign tick    = preTick && (dvCnt >= dvLimit);
  assign expire  = tick && (count == '0) && !ctl.loadCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      psCnt   <= '0;
      dvCnt   <= '0;
      count   <= '1;
      irqPend <= 1'b0;
      rstReq  <= 1'b0;
    end else begin
      if (!ctl.run || preTick) psCnt <= '0;
      else                     psCnt <= psCnt + 1'b1;

      if (!ctl.run || tick) dvCnt <= '0;
      else if (preTick)     dvCnt <= dvCnt + 1'b1;

      if (ctl.loadCnt)  count <= ctl.loadVal;
      else if (tick)    count <= (count == '0) ? ctl.reload : count - 1'b1;

      if (expire && ctl.irqEn) irqPend <= 1'b1;
      else if (ctl.clrIrq)     irqPend <= 1'b0;

      rstReq <= expire && ctl.rstEn;
    end
  end

  p_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !ctl.loadCnt && count != '0) |=> count == $past(count) - 1'b1);
  p_reload_r4: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> count == $past(ctl.reload));
  p_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.clrIrq && !tick) |=> !irqPend);
  p_pulse_one_r6: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> !rstReq);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.run && !ctl.loadCnt) |=> $stable(count));
  p_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.run || !ctl.rstEn) |=> !rstReq);
  p_refresh_r8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadCnt |=> count == $past(ctl.loadVal));
endmodule

// File: rtl/prescaled_wdt.sv
module prescaled_wdt
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut,
  output logic              rstReq
);
  wdt_ctl_t         ctl;
  logic [CNT_W-1:0] cntVal;

  wdt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .cntVal(cntVal), .ctl(ctl)
  );

  wdt_datapath u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .count(cntVal),
    .irqPend(irqOut), .rstReq(rstReq)
  );
endmodule

// File: tb/prescaled_wdt_tb_top.sv
module prescaled_wdt_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        irqOut, rstReq;

  int checks = 0, errors = 0, cycles = 0, rstSeen = 0;

  prescaled_wdt dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irqOut(irqOut), .rstReq(rstReq)
  );

  always #2 clk = ~clk;

  always @(negedge clk) begin
    cycles++;
    if (rstReq) rstSeen++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  typedef struct packed {
    logic        isWr;
    logic [3:0]  addr;
    logic [15:0] val;
    logic [7:0]  req;
  } vec_t;

  // register-map vectors: reads after reset (R1, R9), then write/readback (R2)
  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 4'h0, 16'h0000, 8'd1},
    '{1'b0, 4'h4, 16'hFFFF, 8'd1},
    '{1'b0, 4'h8, 16'hFFFF, 8'd1},
    '{1'b0, 4'hC, 16'h0000, 8'd9},
    '{1'b1, 4'h4, 16'h00AB, 8'd2},
    '{1'b0, 4'h4, 16'h00AB, 8'd2},
    '{1'b1, 4'h0, 16'hFFDE, 8'd2},
    '{1'b0, 4'h0, 16'hFF1C, 8'd2},
    '{1'b1, 4'h8, 16'h0042, 8'd2},
    '{1'b0, 4'h8, 16'h0042, 8'd2},
    '{1'b1, 4'h0, 16'h0000, 8'd2},
    '{1'b0, 4'h0, 16'h0000, 8'd2},
    '{1'b0, 4'h2, 16'h0000, 8'd2},
    '{1'b0, 4'h4, 16'h00AB, 8'd2}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    addr = a; rdEn = 1'b1;
    #1 d = rdData;
    rdEn = 1'b0;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    chk("R1 irqOut", {15'd0, irqOut}, 16'd0);
    chk("R1 rstReq", {15'd0, rstReq}, 16'd0);
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].isWr) wr(VECS[i].addr, VECS[i].val);
      else begin
        rd(VECS[i].addr, v);
        chk($sformatf("R%0d vec %0d", VECS[i].req, i), v, VECS[i].val);
      end
    end

    // R3: P=2, divide by 32 -> 96 cycles per step
    wr(4'h4, 16'd5); wr(4'h8, 16'd3); wr(4'h0, 16'h0228);
    step(95); rd(4'h8, v); chk("R3 before first tick", v, 16'd3);
    step(1);  rd(4'h8, v); chk("R3 first tick", v, 16'd2);
    step(95); rd(4'h8, v); chk("R3 before second tick", v, 16'd2);
    step(1);  rd(4'h8, v); chk("R3 second tick", v, 16'd1);
    wr(4'h0, 16'h0000);

    // R4 R5 R6: expiry with interrupt and reset enabled, period 16
    wr(4'h4, 16'd4); wr(4'h8, 16'd1); wr(4'h0, 16'h0025);
    step(16); rd(4'h8, v); chk("R3 step to zero", v, 16'd0);
    step(15); chk("R5 irq before expiry", {15'd0, irqOut}, 16'd0);
    step(1);  rd(4'h8, v); chk("R4 reload on expiry", v, 16'd4);
    chk("R5 irq set", {15'd0, irqOut}, 16'd1);
    chk("R6 reset pulse high", {15'd0, rstReq}, 16'd1);
    step(1);  chk("R6 reset pulse one cycle", {15'd0, rstReq}, 16'd0);
    chk("R5 irq held", {15'd0, irqOut}, 16'd1);
    wr(4'h0, 16'h0000);
    rd(4'hC, v); chk("R9 clear offset reads zero", v, 16'd0);
    step(1); chk("R9 read leaves irq", {15'd0, irqOut}, 16'd1);
    wr(4'hC, 16'hABCD);
    chk("R5 irq cleared", {15'd0, irqOut}, 16'd0);

    // R10: run only
    wr(4'h4, 16'd7); wr(4'h8, 16'd0); wr(4'h0, 16'h0020);
    step(15); rd(4'h8, v); chk("R10 before expiry", v, 16'd0);
    step(1);  rd(4'h8, v); chk("R10 reload", v, 16'd7);
    chk("R10 no irq", {15'd0, irqOut}, 16'd0);
    chk("R10 no reset", {15'd0, rstReq}, 16'd0);
    wr(4'h0, 16'h0000);

    // R7: stopped with enables set, then restart timing
    wr(4'h8, 16'd9); wr(4'h0, 16'h0005);
    step(300); rd(4'h8, v); chk("R7 hold while stopped", v, 16'd9);
    wr(4'h0, 16'h0020); step(10);
    wr(4'h0, 16'h0000); wr(4'h0, 16'h0020);
    step(15); rd(4'h8, v); chk("R7 full period after restart", v, 16'd9);
    step(1);  rd(4'h8, v); chk("R7 tick after restart", v, 16'd8);
    wr(4'h0, 16'h0000);

    // R8: refresh on the same edge as a tick
    wr(4'h8, 16'd5); wr(4'h0, 16'h0020);
    step(15); wr(4'h8, 16'h1234);
    rd(4'h8, v); chk("R8 refresh wins over tick", v, 16'h1234);
    step(15); rd(4'h8, v); chk("R8 hold after refresh", v, 16'h1234);
    step(1);  rd(4'h8, v); chk("R8 next tick", v, 16'h1233);
    wr(4'h0, 16'h0000);

    chk("R6 total reset pulses", 16'(rstSeen), 16'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule